// File: doc/BRIEF.md
# Non-Excepting Load Fault Checker

This block judges a speculative load before it is sent to memory. For each request it forms the effective address, checks that address against the access size, and checks that the destination register index suits the access width. No fault is raised. A detected problem is deferred: the destination register's not-excepted (NE) flag is set and, when recording is switched on, a status record with a matching address entry is filled in for later recovery.

The block keeps two 64-bit NE flag vectors, one for the integer register set and one for the float register set. A load that finds no fault of its own still inherits poison: if the base register, or the displacement register when one is used, already carries an NE flag, the destination is flagged and the load is suppressed. A clean load clears the destination's flag and may proceed. The verdict appears one cycle after the request strobe. The record table has eight entries and can be inspected through a combinational read port.

Top module: `nxl_load_judge`

## Requirements
- R1: After reset, res_vld, res_go, res_ovf and res_alloc are low, both NE vectors are all zero, and every record reads back as not valid with all fields zero.
- R2: The effective address is base_val + disp_val when disp_use is 1 and base_val + imm_val when disp_use is 0, modulo 2^XLEN. It is the value written into an allocated record's address entry.
- R3: size_code encodes 0 = byte, 1 = halfword, 2 = word, 3 = doubleword, 4 = quadword; codes 5 to 7 never fault. A memory-alignment fault exists when the address has bit 0 set for a halfword, any of bits 1:0 set for a word, any of bits 2:0 set for a doubleword, or any of bits 3:0 set for a quadword. A fault sets the destination's NE flag.
- R4: A register-alignment fault exists when a doubleword has an odd tgt_idx, or a quadword has a tgt_idx that is not a multiple of 4. It sets the destination's NE flag.
- R5: With no fault, the destination's NE flag is set and res_go is 0 if the base register's flag is set, or if disp_use is 1 and the displacement register's flag is set. Otherwise the destination flag is cleared and res_go is 1. Any request that has a fault reports res_go = 1.
- R6: Flags are read and written in fp_ne when req_fp is 1 and in int_ne when req_fp is 0. The other vector is left unchanged, and neither vector changes without a request.
- R7: Recording is active only when ctl_valid and ctl_en are both 1. Without it no record changes, and res_alloc and res_ovf stay 0.
- R8: With recording active, the record allocated is the lowest-indexed record that is not valid and whose index is below ctl_count. ctl_count values above 8 count as 8.
- R9: An allocated record reads back valid = 1, address-valid = 1, destination = tgt_idx, size = size_code, own index = its slot number, float bit = req_fp, mem_err = the R3 fault and reg_err = the R4 fault. res_alloc = 1 and res_slot gives that slot.
- R10: With recording active and no eligible free record, res_ovf is 1, res_alloc is 0, the table is unchanged, and the NE flags are still updated.
- R11: res_vld is 1 exactly in the cycle after a cycle with req_vld = 1. res_go, res_ovf, res_alloc and res_slot are zero whenever res_vld is 0. Back-to-back requests see each other's flag and table updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe |
| req_fp | input | 1 | 1 = float destination, 0 = integer |
| base_idx | input | 6 | Base register index |
| disp_idx | input | 6 | Displacement register index |
| disp_use | input | 1 | 1 = add the displacement register, 0 = add the immediate |
| tgt_idx | input | 6 | Destination register index |
| size_code | input | 3 | Access size code (see R3) |
| base_val | input | 32 | Base register value |
| disp_val | input | 32 | Displacement register value |
| imm_val | input | 32 | Immediate displacement |
| ctl_valid | input | 1 | Recording control is valid |
| ctl_en | input | 1 | Recording enable |
| ctl_count | input | 4 | Number of usable records |
| rd_sel | input | 3 | Record read-port select |
| res_vld | output | 1 | Verdict valid |
| res_go | output | 1 | Load may proceed |
| res_ovf | output | 1 | Recording active but no record free |
| res_alloc | output | 1 | A record was allocated |
| res_slot | output | 3 | Allocated record index |
| int_ne | output | 64 | Integer NE flag vector |
| fp_ne | output | 64 | Float NE flag vector |
| rd_valid | output | 1 | Selected record: valid |
| rd_addr_ok | output | 1 | Selected record: address valid |
| rd_dst | output | 6 | Selected record: destination index |
| rd_size | output | 3 | Selected record: size code |
| rd_own | output | 3 | Selected record: own index |
| rd_fp | output | 1 | Selected record: float bit |
| rd_mem_err | output | 1 | Selected record: memory-alignment fault |
| rd_reg_err | output | 1 | Selected record: register-alignment fault |
| rd_addr | output | 32 | Selected record: effective address |

## Verification
The bench uses the default parameters: 64 registers per set, 32-bit addresses and eight records. With eight records the table fills after a handful of requests, so both overflow paths can be reached: the one set by a small ctl_count and the one where the table is full while ctl_count is clamped above 8. The full 64-bit vectors let every size code be swept against every low-address pattern, and every doubleword and quadword destination alignment be tried, without one sweep poisoning another's sources.

// File: rtl/nxl_pkg.sv
package nxl_pkg;

  localparam logic [2:0] SZ_BYTE = 3'd0;
  localparam logic [2:0] SZ_HALF = 3'd1;
  localparam logic [2:0] SZ_WORD = 3'd2;
  localparam logic [2:0] SZ_DBL  = 3'd3;
  localparam logic [2:0] SZ_QUAD = 3'd4;

  // Memory alignment fault from the four low address bits.
  function automatic logic addr_fault(input logic [3:0] lo, input logic [2:0] sz);
    logic f;
    case (sz)
      SZ_HALF: f = lo[0];
      SZ_WORD: f = |lo[1:0];
      SZ_DBL:  f = |lo[2:0];
      SZ_QUAD: f = |lo;
      default: f = 1'b0;
    endcase
    return f;
  endfunction

  // Destination register alignment fault from the two low index bits.
  function automatic logic regidx_fault(input logic [1:0] lo, input logic [2:0] sz);
    logic f;
    case (sz)
      SZ_DBL:  f = lo[0];
      SZ_QUAD: f = |lo;
      default: f = 1'b0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/nxl_rst_sync.sv
module nxl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/nxl_addr_check.sv
module nxl_addr_check
  import nxl_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 6
) (
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   disp_val,
  input  logic [XLEN-1:0]   imm_val,
  input  logic              disp_use,
  input  logic [2:0]        size_code,
  input  logic [RIDX_W-1:0] tgt_idx,
  output logic [XLEN-1:0]   eff_addr,
  output logic              mem_err,
  output logic              reg_err
);
  logic [XLEN-1:0] offset;

  always_comb begin
    offset   = disp_use ? disp_val : imm_val;
    eff_addr = base_val + offset;
    mem_err  = addr_fault(eff_addr[3:0], size_code);
    reg_err  = regidx_fault(tgt_idx[1:0], size_code);
  end
endmodule

// File: rtl/nxl_ne_file.sv
module nxl_ne_file #(
  parameter int NREG   = 64,
  parameter int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              upd_fp,
  input  logic [RIDX_W-1:0] upd_idx,
  input  logic              upd_val,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [RIDX_W-1:0] disp_idx,
  input  logic              disp_use,
  output logic              src_poison,
  output logic [NREG-1:0]   int_ne,
  output logic [NREG-1:0]   fp_ne
);
  logic [NREG-1:0] int_q, int_d;
  logic [NREG-1:0] fp_q,  fp_d;
  logic [NREG-1:0] sel_vec;

  // Sources are looked up in the vector of the request's own register set.
  always_comb begin
    sel_vec    = upd_fp ? fp_q : int_q;
    src_poison = sel_vec[base_idx] | (disp_use & sel_vec[disp_idx]);
  end

  always_comb begin
    int_d = int_q;
    fp_d  = fp_q;
    if (upd_fp) fp_d[upd_idx]  = upd_val;
    else        int_d[upd_idx] = upd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= '0;
      fp_q  <= '0;
    end else if (upd_en) begin
      int_q <= int_d;
      fp_q  <= fp_d;
    end
  end

  assign int_ne = int_q;
  assign fp_ne  = fp_q;
endmodule

// File: rtl/nxl_rec_table.sv
module nxl_rec_table #(
  parameter int NREC   = 8,
  parameter int RIDX_W = 6,
  parameter int XLEN   = 32,
  parameter int SLOT_W = $clog2(NREC),
  parameter int CNT_W  = $clog2(NREC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [CNT_W-1:0]  lim_raw,
  input  logic [RIDX_W-1:0] wr_dst,
  input  logic [2:0]        wr_size,
  input  logic              wr_fp,
  input  logic              wr_merr,
  input  logic              wr_rerr,
  input  logic [XLEN-1:0]   wr_addr,
  input  logic [SLOT_W-1:0] rd_sel,
  output logic              alloc_ok,
  output logic              no_room,
  output logic [SLOT_W-1:0] alloc_slot,
  output logic              rd_valid,
  output logic              rd_addr_ok,
  output logic [RIDX_W-1:0] rd_dst,
  output logic [2:0]        rd_size,
  output logic [SLOT_W-1:0] rd_own,
  output logic              rd_fp,
  output logic              rd_mem_err,
  output logic              rd_reg_err,
  output logic [XLEN-1:0]   rd_addr
);
  localparam logic [CNT_W-1:0] LIM_MAX = CNT_W'(NREC);

  logic [NREC-1:0]   vld_arr, av_arr, fp_arr, me_arr, re_arr;
  logic [RIDX_W-1:0] dst_arr  [NREC];
  logic [2:0]        sz_arr   [NREC];
  logic [SLOT_W-1:0] own_arr  [NREC];
  logic [XLEN-1:0]   addr_arr [NREC];

  logic [CNT_W-1:0]  lim;
  logic              found;
  logic [SLOT_W-1:0] pick;

  assign lim = (lim_raw > LIM_MAX) ? LIM_MAX : lim_raw;

  // Lowest free record below the usable count wins.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NREC - 1; i >= 0; i--) begin
      if (!vld_arr[i] && (CNT_W'(i) < lim)) begin
        found = 1'b1;
        pick  = SLOT_W'(i);
      end
    end
  end

  assign alloc_ok   = active & found;
  assign no_room    = active & ~found;
  assign alloc_slot = pick;

  for (genvar g = 0; g < NREC; g++) begin : g_slot
    logic              we;
    logic              vld_q, av_q, fp_q, me_q, re_q;
    logic [RIDX_W-1:0] dst_q;
    logic [2:0]        sz_q;
    logic [SLOT_W-1:0] own_q;
    logic [XLEN-1:0]   addr_q;

    assign we = alloc_ok && (pick == SLOT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        av_q   <= 1'b0;
        fp_q   <= 1'b0;
        me_q   <= 1'b0;
        re_q   <= 1'b0;
        dst_q  <= '0;
        sz_q   <= '0;
        own_q  <= '0;
        addr_q <= '0;
      end else if (we) begin
        vld_q  <= 1'b1;
        av_q   <= 1'b1;
        fp_q   <= wr_fp;
        me_q   <= wr_merr;
        re_q   <= wr_rerr;
        dst_q  <= wr_dst;
        sz_q   <= wr_size;
        own_q  <= SLOT_W'(g);
        addr_q <= wr_addr;
      end
    end

    assign vld_arr[g]  = vld_q;
    assign av_arr[g]   = av_q;
    assign fp_arr[g]   = fp_q;
    assign me_arr[g]   = me_q;
    assign re_arr[g]   = re_q;
    assign dst_arr[g]  = dst_q;
    assign sz_arr[g]   = sz_q;
    assign own_arr[g]  = own_q;
    assign addr_arr[g] = addr_q;
  end

  always_comb begin
    rd_valid   = vld_arr[rd_sel];
    rd_addr_ok = av_arr[rd_sel];
    rd_fp      = fp_arr[rd_sel];
    rd_mem_err = me_arr[rd_sel];
    rd_reg_err = re_arr[rd_sel];
    rd_dst     = dst_arr[rd_sel];
    rd_size    = sz_arr[rd_sel];
    rd_own     = own_arr[rd_sel];
    rd_addr    = addr_arr[rd_sel];
  end
endmodule

// File: rtl/nxl_load_judge.sv
module nxl_load_judge #(
  parameter int  NREG   = 64,
  parameter int  XLEN   = 32,
  parameter int  NREC   = 8,
  localparam int RIDX_W = $clog2(NREG),
  localparam int SLOT_W = $clog2(NREC),
  localparam int CNT_W  = $clog2(NREC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              req_fp,
  input  logic [RIDX_W-1:0] base_idx,
  input  logic [RIDX_W-1:0] disp_idx,
  input  logic              disp_use,
  input  logic [RIDX_W-1:0] tgt_idx,
  input  logic [2:0]        size_code,
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   disp_val,
  input  logic [XLEN-1:0]   imm_val,
  input  logic              ctl_valid,
  input  logic              ctl_en,
  input  logic [CNT_W-1:0]  ctl_count,
  input  logic [SLOT_W-1:0] rd_sel,
  output logic              res_vld,
  output logic              res_go,
  output logic              res_ovf,
  output logic              res_alloc,
  output logic [SLOT_W-1:0] res_slot,
  output logic [NREG-1:0]   int_ne,
  output logic [NREG-1:0]   fp_ne,
  output logic              rd_valid,
  output logic              rd_addr_ok,
  output logic [RIDX_W-1:0] rd_dst,
  output logic [2:0]        rd_size,
  output logic [SLOT_W-1:0] rd_own,
  output logic              rd_fp,
  output logic              rd_mem_err,
  output logic              rd_reg_err,
  output logic [XLEN-1:0]   rd_addr
);
  logic              rst_q_n;
  logic [XLEN-1:0]   eff_addr;
  logic              mem_err, reg_err, fault;
  logic              poison, tgt_flag, load_ok;
  logic              rec_on;
  logic              tbl_alloc, tbl_full;
  logic [SLOT_W-1:0] tbl_slot;

  logic              vld_d, go_d, ovf_d, alloc_d;
  logic [SLOT_W-1:0] slot_d;
  logic              vld_q, go_q, ovf_q, alloc_q;
  logic [SLOT_W-1:0] slot_q;

  nxl_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_q_n (rst_q_n)
  );

  nxl_addr_check #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk_addr (
    .base_val  (base_val),
    .disp_val  (disp_val),
    .imm_val   (imm_val),
    .disp_use  (disp_use),
    .size_code (size_code),
    .tgt_idx   (tgt_idx),
    .eff_addr  (eff_addr),
    .mem_err   (mem_err),
    .reg_err   (reg_err)
  );

  // A fault of its own flags the target; otherwise it inherits source poison.
  assign fault    = mem_err | reg_err;
  assign tgt_flag = fault | poison;
  assign load_ok  = fault | ~poison;
  assign rec_on   = ctl_valid & ctl_en;

  nxl_ne_file #(.NREG(NREG), .RIDX_W(RIDX_W)) u_ne (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .upd_en     (req_vld),
    .upd_fp     (req_fp),
    .upd_idx    (tgt_idx),
    .upd_val    (tgt_flag),
    .base_idx   (base_idx),
    .disp_idx   (disp_idx),
    .disp_use   (disp_use),
    .src_poison (poison),
    .int_ne     (int_ne),
    .fp_ne      (fp_ne)
  );

  nxl_rec_table #(
    .NREC(NREC), .RIDX_W(RIDX_W), .XLEN(XLEN), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
  ) u_tbl (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .active     (req_vld & rec_on),
    .lim_raw    (ctl_count),
    .wr_dst     (tgt_idx),
    .wr_size    (size_code),
    .wr_fp      (req_fp),
    .wr_merr    (mem_err),
    .wr_rerr    (reg_err),
    .wr_addr    (eff_addr),
    .rd_sel     (rd_sel),
    .alloc_ok   (tbl_alloc),
    .no_room    (tbl_full),
    .alloc_slot (tbl_slot),
    .rd_valid   (rd_valid),
    .rd_addr_ok (rd_addr_ok),
    .rd_dst     (rd_dst),
    .rd_size    (rd_size),
    .rd_own     (rd_own),
    .rd_fp      (rd_fp),
    .rd_mem_err (rd_mem_err),
    .rd_reg_err (rd_reg_err),
    .rd_addr    (rd_addr)
  );

  always_comb begin
    vld_d   = req_vld;
    go_d    = 1'b0;
    ovf_d   = 1'b0;
    alloc_d = 1'b0;
    slot_d  = '0;
    if (req_vld) begin
      go_d    = load_ok;
      ovf_d   = tbl_full;
      alloc_d = tbl_alloc;
      slot_d  = tbl_alloc ? tbl_slot : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q   <= 1'b0;
      go_q    <= 1'b0;
      ovf_q   <= 1'b0;
      alloc_q <= 1'b0;
      slot_q  <= '0;
    end else begin
      vld_q   <= vld_d;
      go_q    <= go_d;
      ovf_q   <= ovf_d;
      alloc_q <= alloc_d;
      slot_q  <= slot_d;
    end
  end

  assign res_vld   = vld_q;
  assign res_go    = go_q;
  assign res_ovf   = ovf_q;
  assign res_alloc = alloc_q;
  assign res_slot  = slot_q;
endmodule

// File: rtl/nxl_load_judge_chk.sv
module nxl_load_judge_chk #(
  parameter int NREG   = 64,
  parameter int NREC   = 8,
  parameter int RIDX_W = 6,
  parameter int SLOT_W = 3,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic              req_fp,
  input logic [RIDX_W-1:0] tgt_idx,
  input logic              ctl_valid,
  input logic              ctl_en,
  input logic [CNT_W-1:0]  ctl_count,
  input logic              res_vld,
  input logic              res_go,
  input logic              res_ovf,
  input logic              res_alloc,
  input logic [SLOT_W-1:0] res_slot,
  input logic [NREG-1:0]   int_ne,
  input logic [NREG-1:0]   fp_ne
);
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> res_vld); // R11
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !res_vld); // R11
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> !(res_go || res_ovf || res_alloc)); // R11
  AST_NE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> ($stable(int_ne) && $stable(fp_ne))); // R6
  AST_STOP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_go) |-> ($past(req_fp) ? fp_ne[$past(tgt_idx)] : int_ne[$past(tgt_idx)])); // R5
  AST_REC_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (res_alloc || res_ovf) |-> $past(ctl_valid && ctl_en)); // R7
  AST_SLOT_UNDER_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    res_alloc |-> (CNT_W'(res_slot) < $past(ctl_count))); // R8
  AST_NO_OVERFLOW_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_ovf && res_alloc)); // R10
endmodule

bind nxl_load_judge nxl_load_judge_chk #(
  .NREG(NREG), .NREC(NREC), .RIDX_W(RIDX_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
) u_nxl_chk (
  .rst_n(rst_q_n),
  .*
);

// File: tb/nxl_load_judge_tb.sv
`timescale 1ns/1ps
module nxl_load_judge_tb;
  localparam int NREC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0, req_fp = 1'b0, disp_use = 1'b0;
  logic [5:0]  base_idx = '0, disp_idx = '0, tgt_idx = '0;
  logic [2:0]  size_code = '0;
  logic [31:0] base_val = '0, disp_val = '0, imm_val = '0;
  logic        ctl_valid = 1'b0, ctl_en = 1'b0;
  logic [3:0]  ctl_count = '0;
  logic [2:0]  rd_sel = '0;
  logic        res_vld, res_go, res_ovf, res_alloc;
  logic [2:0]  res_slot;
  logic [63:0] int_ne, fp_ne;
  logic        rd_valid, rd_addr_ok, rd_fp, rd_mem_err, rd_reg_err;
  logic [5:0]  rd_dst;
  logic [2:0]  rd_size, rd_own;
  logic [31:0] rd_addr;

  nxl_load_judge u_dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit run = 0, done = 0;

  // Behavioural reference state
  bit [63:0] m_int = '0, m_fp = '0;
  bit        m_vld = 0;
  bit        r_vld[NREC], r_fp[NREC], r_me[NREC], r_re[NREC];
  int        r_dst[NREC], r_sz[NREC], r_own[NREC];
  bit [31:0] r_addr[NREC];

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_rec(int i);
    rd_sel = 3'(i);
    #1;
    chk("R9", $sformatf("rec%0d valid", i), rd_valid, r_vld[i]);
    chk("R9", $sformatf("rec%0d addr_ok", i), rd_addr_ok, r_vld[i]);
    chk("R9", $sformatf("rec%0d dst", i), rd_dst, r_dst[i]);
    chk("R9", $sformatf("rec%0d size", i), rd_size, r_sz[i]);
    chk("R9", $sformatf("rec%0d own", i), rd_own, r_own[i]);
    chk("R9", $sformatf("rec%0d fp", i), rd_fp, r_fp[i]);
    chk("R3", $sformatf("rec%0d mem_err", i), rd_mem_err, r_me[i]);
    chk("R4", $sformatf("rec%0d reg_err", i), rd_reg_err, r_re[i]);
    chk("R2", $sformatf("rec%0d addr", i), rd_addr, r_addr[i]);
  endtask

  task automatic chk_all_recs();
    for (int i = 0; i < NREC; i++) chk_rec(i);
  endtask

  // Called at a falling edge; returns at the next falling edge with results checked.
  task automatic issue(bit fp, int b, int d, bit du, bit [31:0] bv, bit [31:0] dv,
                       bit [31:0] iv, int t, int sz, bit cv, bit ce, int cnt, string tag);
    bit [31:0] a, mask;
    bit me, re, poison, flag, go, on, found, e_ovf;
    bit [63:0] vec;
    int lim, slot;
    a = bv + (du ? dv : iv);
    mask = (sz == 1) ? 32'h1 : (sz == 2) ? 32'h3 : (sz == 3) ? 32'h7 : (sz == 4) ? 32'hF : 32'h0;
    me = (a & mask) != 0;
    re = (sz == 3) ? (t % 2 != 0) : (sz == 4) ? (t % 4 != 0) : 1'b0;
    vec = fp ? m_fp : m_int;
    poison = vec[b] || (du && vec[d]);
    flag = me || re || poison;
    go = !(!me && !re && poison);
    on = cv && ce;
    lim = (cnt > NREC) ? NREC : cnt;
    found = 0; slot = 0;
    for (int i = 0; i < lim; i++) if (!found && !r_vld[i]) begin found = 1; slot = i; end
    e_ovf = on && !found;
    // drive
    req_vld = 1; req_fp = fp; base_idx = 6'(b); disp_idx = 6'(d); disp_use = du;
    base_val = bv; disp_val = dv; imm_val = iv; tgt_idx = 6'(t); size_code = 3'(sz);
    ctl_valid = cv; ctl_en = ce; ctl_count = 4'(cnt);
    // model update
    m_vld = 1;
    if (fp) m_fp[t] = flag; else m_int[t] = flag;
    if (on && found) begin
      r_vld[slot] = 1; r_dst[slot] = t; r_sz[slot] = sz; r_own[slot] = slot;
      r_fp[slot] = fp; r_me[slot] = me; r_re[slot] = re; r_addr[slot] = a;
    end
    @(negedge clk);
    req_vld = 0; m_vld = 0;
    chk("R11", "res_vld", res_vld, 1'b1);
    chk("R5", "res_go", res_go, go);
    chk("R10", "res_ovf", res_ovf, e_ovf);
    chk("R8", "res_alloc", res_alloc, on && found);
    if (on && found) chk("R8", "res_slot", res_slot, slot);
    chk(tag, "target flag", fp ? fp_ne[t] : int_ne[t], flag);
  endtask

  // Every-clock comparison against the reference
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (run && !done) begin
        chk("R11", "res_vld per clock", res_vld, m_vld);
        chk("R6", "int_ne per clock", int_ne, m_int);
        chk("R6", "fp_ne per clock", fp_ne, m_fp);
        if (!res_vld) chk("R11", "idle outputs", {res_go, res_ovf, res_alloc, res_slot}, '0);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREC; i++) begin
      r_vld[i] = 0; r_fp[i] = 0; r_me[i] = 0; r_re[i] = 0;
      r_dst[i] = 0; r_sz[i] = 0; r_own[i] = 0; r_addr[i] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "res_vld", res_vld, 1'b0);
    chk("R1", "res flags", {res_go, res_ovf, res_alloc}, 3'b000);
    chk("R1", "int_ne", int_ne, '0);
    chk("R1", "fp_ne", fp_ne, '0);
    for (int i = 0; i < NREC; i++) begin
      rd_sel = 3'(i); #1;
      chk("R1", "record valid", rd_valid, 1'b0);
      chk("R1", "record addr", rd_addr, '0);
    end
    @(negedge clk);
    run = 1;

    // R7 recording gated off; R3 fault without recording
    issue(0, 1, 0, 0, 32'h1000, 0, 32'h4, 3, 2, 1, 0, 8, "R7");
    issue(0, 1, 0, 0, 32'h1001, 0, 32'h0, 5, 2, 1, 0, 8, "R3");
    issue(0, 1, 0, 0, 32'h1001, 0, 32'h0, 9, 1, 0, 1, 8, "R7");

    // R5 poisoning and clearing
    issue(0, 5, 0, 0, 32'h2000, 0, 0, 6, 0, 0, 0, 0, "R5");
    issue(0, 1, 5, 1, 32'h2000, 32'h10, 0, 7, 0, 0, 0, 0, "R5");
    issue(0, 1, 5, 0, 32'h2000, 32'h10, 0, 8, 0, 0, 0, 0, "R5");
    issue(0, 1, 2, 1, 32'h2000, 32'h10, 0, 5, 2, 0, 0, 0, "R5");
    issue(0, 6, 0, 0, 32'h2003, 0, 0, 11, 2, 0, 0, 0, "R5"); // fault + poison: go high

    // R6 vector select
    issue(1, 0, 0, 0, 32'h3004, 0, 0, 3, 3, 0, 0, 0, "R6");
    issue(1, 6, 0, 0, 32'h3000, 0, 0, 4, 0, 0, 0, 0, "R6");
    issue(1, 3, 0, 0, 32'h3000, 0, 0, 12, 0, 0, 0, 0, "R6");

    // R3 size / low-address sweep
    for (int sz = 0; sz < 8; sz++)
      for (int lo = 0; lo < 16; lo++)
        issue(0, 0, 0, 0, 32'h4000 + 32'(lo), 0, 0, 10, sz, 0, 0, 0, "R3");

    // R4 destination alignment sweep
    for (int sz = 3; sz <= 4; sz++)
      for (int t = 32; t < 48; t++)
        issue(0, 0, 0, 0, 32'h5000, 0, 0, t, sz, 0, 0, 0, "R4");

    // R8 / R10 count of zero overflows
    issue(0, 0, 0, 0, 32'h6000, 0, 0, 13, 0, 1, 1, 0, "R10");
    chk_all_recs();

    // R2 / R9 allocation with a small count
    issue(0, 0, 2, 1, 32'h100, 32'h23, 0, 12, 1, 1, 1, 3, "R2");
    issue(1, 0, 0, 0, 32'h400, 0, 32'hFFFF_FFF0, 6, 4, 1, 1, 3, "R4");
    issue(0, 0, 0, 0, 32'h800, 0, 32'h8, 14, 2, 1, 1, 3, "R9");
    issue(0, 0, 0, 0, 32'h900, 0, 32'h1, 15, 2, 1, 1, 3, "R10");
    chk_all_recs();

    // R8 count above the table size is clamped
    for (int k = 0; k < 6; k++)
      issue(k % 2, 0, 0, 0, 32'hA00 + 32'(k * 3), 0, 0, 16 + k, k % 5, 1, 1, 15, "R8");
    chk_all_recs();
    issue(0, 0, 0, 0, 32'hB00, 0, 0, 22, 0, 0, 1, 15, "R7");

    // R11 back-to-back dependency
    issue(0, 0, 0, 0, 32'hC02, 0, 0, 20, 2, 0, 0, 0, "R11");
    issue(0, 20, 0, 0, 32'hC00, 0, 0, 21, 2, 0, 0, 0, "R11");
    issue(0, 1, 0, 0, 32'hC00, 0, 0, 20, 2, 0, 0, 0, "R11");
    repeat (3) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule